// File: doc/BRIEF.md
# Burst Beat Address Generator

This block takes one accepted address-channel request for an AXI burst and turns it into the sequence of byte addresses that each beat of that burst targets. The request carries a start address, a size code, a length code and a burst type. The block derives the bytes per beat as 2 to the power of the size code, the beat count as the length code plus one, and the size-aligned form of the start address. It then walks the burst one beat at a time.

Beats leave on a valid/ready pair. A beat moves only on a cycle where both signals are high, and the final beat is marked. The very first beat always carries the issued address unchanged, even if that address is unaligned. After that, fixed bursts repeat the issued address, incrementing bursts step from the aligned address, and wrapping bursts step but fold back inside a block whose size is the bytes per beat times the beat count.

Requests that cannot be honoured as written are still completed as incrementing bursts, and an error flag is raised for them. A new request is taken only while no burst is in flight.

Top module: `burst_addr_gen`

## Requirements
- R1: After a synchronous reset, `beat_valid` is low, `beat_last` is low, `beat_err` is low and `req_ready` is high.
- R2: `req_ready` is high only while no burst is in flight. A request presented while `req_ready` is low is ignored and does not change the addresses of the running burst.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. In the next cycle `beat_valid` is high and `beat_addr` equals the issued address exactly, whatever its alignment.
- R4: Burst type 2'b00 (fixed): every beat's address equals the issued address.
- R5: Burst type 2'b01 (incrementing): beat N, for N of 2 or more, targets the issued address with its low `req_size` bits cleared, plus (N-1) times 2^`req_size`.
- R6: Burst type 2'b10 (wrapping), with a block of 2^`req_size` times (`req_len`+1) bytes: beats step as in R5, and an address that would reach the block base plus the block size returns to the block base. The block base is the issued address rounded down to a multiple of the block size.
- R7: A burst has exactly `req_len`+1 beats. `beat_last` is high with the final beat only. After the final beat's handshake, `beat_valid` is low and `req_ready` is high in the next cycle.
- R8: While `beat_valid` is high and `beat_ready` is low, `beat_valid`, `beat_addr` and `beat_last` hold their values.
- R9: Burst type 2'b11 is run as incrementing, with `beat_err` high on every beat of that burst.
- R10: A wrapping request whose beat count is not 2, 4, 8 or 16, or whose issued address is not a multiple of 2^`req_size`, is run as incrementing, with `beat_err` high on every beat. For legal requests `beat_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Generator idle and able to take a request |
| req_addr | input | AW | Issued start address |
| req_size | input | 3 | Size code; bytes per beat = 2^code |
| req_len | input | 8 | Length code; beats = code + 1 |
| req_burst | input | 2 | Burst type: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| beat_valid | output | 1 | A beat address is offered |
| beat_ready | input | 1 | Downstream takes the offered beat |
| beat_addr | output | AW | Target address of the offered beat |
| beat_last | output | 1 | Offered beat is the final one of the burst |
| beat_err | output | 1 | Current burst was requested in a form that is not allowed |

## Verification
The completion of one burst and the arrival of the next request can fall in the same cycle. The bench raises `req_valid` with a fresh request during the final beat's handshake. It checks that the request is refused in that cycle, is then taken one cycle later from idle, and starts with its own issued address. A stall can also fall on the beat where a wrapping burst folds back or on the last beat. The bench holds `beat_ready` low on exactly those beats and requires the address and last flag to stay put until the handshake completes.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int SIZE_W = 3;
    localparam int LEN_W  = 8;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } burst_e;

    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_LINEAR = 2'd1,
        STEP_FOLD   = 2'd2
    } step_e;

    typedef struct packed {
        step_e              step;
        logic [SIZE_W-1:0]  size;
        logic [LEN_W-1:0]   len;
        logic               err;
    } plan_t;

    function automatic logic wrap_len_ok(input logic [LEN_W-1:0] len);
        return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    endfunction

endpackage

// File: rtl/burst_req_decode.sv
module burst_req_decode
    import burst_addr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]     addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [LEN_W-1:0]  len,
    input  logic [1:0]        burst,
    output plan_t             plan
);
    logic [AW-1:0] low_mask;
    logic          misaligned;

    always_comb begin
        low_mask   = (AW'(1) << size) - AW'(1);
        misaligned = (addr & low_mask) != '0;
        plan.size  = size;
        plan.len   = len;
        plan.err   = 1'b0;
        plan.step  = STEP_LINEAR;
        unique case (burst_e'(burst))
            BT_FIXED: plan.step = STEP_HOLD;
            BT_INCR:  plan.step = STEP_LINEAR;
            BT_WRAP: begin
                if (wrap_len_ok(len) && !misaligned) begin
                    plan.step = STEP_FOLD;
                end else begin
                    plan.err  = 1'b1;
                end
            end
            default:  plan.err = 1'b1;
        endcase
    end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
    import burst_addr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          adv,
    input  plan_t         plan,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] nbytes;
    logic [AW-1:0] blk_mask;
    logic [AW-1:0] aligned;
    logic [AW-1:0] stepped;
    logic [AW-1:0] next_addr;

    always_comb begin
        nbytes    = AW'(1) << plan.size;
        blk_mask  = ((AW'(plan.len) + AW'(1)) << plan.size) - AW'(1);
        aligned   = addr & ~(nbytes - AW'(1));
        stepped   = aligned + nbytes;
        unique case (plan.step)
            STEP_HOLD:  next_addr = addr;
            STEP_FOLD:  next_addr = (addr & ~blk_mask) | (stepped & blk_mask);
            default:    next_addr = stepped;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (adv) begin
            addr <= next_addr;
        end
    end

    p_fixed_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && plan.step == STEP_HOLD) |=> (addr == $past(addr)));

    p_linear_step_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && plan.step == STEP_LINEAR) |=> (addr > $past(addr) || addr == '0));

    p_fold_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && plan.step == STEP_FOLD) |=>
            ((addr & ~blk_mask) == ($past(addr) & ~blk_mask)));
endmodule

// File: rtl/burst_beat_count.sv
module burst_beat_count
    import burst_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             adv,
    output logic             last
);
    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= len;
        end else if (adv && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign last = (remain == '0);

    p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && !last) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        req_burst,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [AW-1:0]     beat_addr,
    output logic              beat_last,
    output logic              beat_err
);
    plan_t plan_d;
    plan_t plan_q;
    logic  busy;
    logic  req_fire;
    logic  beat_fire;
    logic  cnt_last;

    assign req_ready = !busy;
    assign req_fire  = req_valid && req_ready;
    assign beat_fire = beat_valid && beat_ready;

    burst_req_decode #(.AW(AW)) u_decode (
        .addr  (req_addr),
        .size  (req_size),
        .len   (req_len),
        .burst (req_burst),
        .plan  (plan_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            plan_q <= '0;
        end else if (req_fire) begin
            busy   <= 1'b1;
            plan_q <= plan_d;
        end else if (beat_fire && cnt_last) begin
            busy   <= 1'b0;
        end
    end

    burst_addr_step #(.AW(AW)) u_step (
        .clk       (clk),
        .rst       (rst),
        .load      (req_fire),
        .load_addr (req_addr),
        .adv       (beat_fire && !cnt_last),
        .plan      (plan_q),
        .addr      (beat_addr)
    );

    burst_beat_count u_count (
        .clk  (clk),
        .rst  (rst),
        .load (req_fire),
        .len  (req_len),
        .adv  (beat_fire),
        .last (cnt_last)
    );

    assign beat_valid = busy;
    assign beat_last  = busy && cnt_last;
    assign beat_err   = busy && plan_q.err;

    p_idle_only_r2: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> !req_ready);

    p_first_addr_r3: assert property (@(posedge clk) disable iff (rst)
        req_fire |=> (beat_valid && beat_addr == $past(req_addr)));

    p_end_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (beat_fire && beat_last) |=> (!beat_valid && req_ready));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=>
            (beat_valid && $stable(beat_addr) && $stable(beat_last)));

    p_last_valid_r7: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid);
endmodule

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic [2:0]    req_size;
    logic [7:0]    req_len;
    logic [1:0]    req_burst;
    logic          beat_valid;
    logic          beat_ready;
    logic [AW-1:0] beat_addr;
    logic          beat_last;
    logic          beat_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.AW(AW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_len(req_len),
        .req_burst(req_burst),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_last(beat_last), .beat_err(beat_err)
    );

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit model_err(input logic [AW-1:0] a, input int sz,
                                     input int ln, input int bt);
        int nb = 1 << sz;
        if (bt == 3) return 1'b1;
        if (bt == 2 && (!(ln == 1 || ln == 3 || ln == 7 || ln == 15) || (a % nb) != 0))
            return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [AW-1:0] model_addr(input logic [AW-1:0] a, input int sz,
                                                 input int ln, input int bt, input int n);
        longint nb  = longint'(1) << sz;
        longint al  = (longint'(a) / nb) * nb;
        longint blk = nb * (ln + 1);
        longint wb  = (longint'(a) / blk) * blk;
        longint x   = al + n * nb;
        int     eff = model_err(a, sz, ln, bt) ? 1 : bt;
        if (n == 0) return a;
        if (eff == 0) return a;
        if (eff == 2 && x >= wb + blk) x = x - blk;
        return AW'(x);
    endfunction

    // Presents a request at a falling edge; it is taken at the next rising edge.
    task automatic issue(input logic [AW-1:0] a, input int sz, input int ln, input int bt);
        req_valid = 1'b1; req_addr = a; req_size = 3'(sz);
        req_len = 8'(ln); req_burst = 2'(bt);
        chk(req_ready == 1'b1, "R2 ready when idle", AW'(req_ready), 1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Drains a burst, stalling on beat stall_at (-1 for none).
    task automatic drain(input logic [AW-1:0] a, input int sz, input int ln, input int bt,
                         input int stall_at, input string tag);
        logic [AW-1:0] exp;
        bit            eerr = model_err(a, sz, ln, bt);
        for (int n = 0; n <= ln; n++) begin
            exp = model_addr(a, sz, ln, bt, n);
            if (n == stall_at) begin
                beat_ready = 1'b0;
                @(posedge clk); @(negedge clk);
                chk(beat_valid && beat_addr == exp, "R8 held under stall", beat_addr, exp);
                chk(beat_last == (n == ln), "R8 last held under stall", AW'(beat_last), AW'(n == ln));
            end
            beat_ready = 1'b1;
            chk(beat_valid == 1'b1, "R7 beat offered", AW'(beat_valid), 1);
            chk(beat_addr == exp, tag, beat_addr, exp);
            chk(beat_last == (n == ln), "R7 last flag", AW'(beat_last), AW'(n == ln));
            chk(beat_err == eerr, "R9 R10 error flag", AW'(beat_err), AW'(eerr));
            chk(req_ready == 1'b0, "R2 busy not ready", AW'(req_ready), 0);
            @(posedge clk); @(negedge clk);
        end
        beat_ready = 1'b0;
    endtask

    task automatic expect_idle();
        chk(beat_valid == 1'b0, "R7 valid drops after last", AW'(beat_valid), 0);
        chk(req_ready == 1'b1, "R7 ready after last", AW'(req_ready), 1);
    endtask

    task automatic run(input logic [AW-1:0] a, input int sz, input int ln, input int bt,
                       input int stall_at, input string tag);
        issue(a, sz, ln, bt);
        chk(beat_addr == a, "R3 first beat exact", beat_addr, a);
        drain(a, sz, ln, bt, stall_at, tag);
        expect_idle();
    endtask

    task automatic t_reset();
        chk(beat_valid == 1'b0, "R1 valid low", AW'(beat_valid), 0);
        chk(beat_last == 1'b0, "R1 last low", AW'(beat_last), 0);
        chk(beat_err == 1'b0, "R1 err low", AW'(beat_err), 0);
        chk(req_ready == 1'b1, "R1 ready high", AW'(req_ready), 1);
    endtask

    task automatic t_busy_ignore();
        logic [AW-1:0] exp;
        issue(32'h100, 2, 3, 1);
        req_valid = 1'b1; req_addr = 32'h7770; req_burst = 2'b00; req_len = 8'd0;
        for (int n = 0; n <= 3; n++) begin
            exp = 32'h100 + 32'(n * 4);
            beat_ready = 1'b1;
            chk(beat_addr == exp, "R2 foreign request ignored", beat_addr, exp);
            chk(req_ready == 1'b0, "R2 not ready while busy", AW'(req_ready), 0);
            @(posedge clk); @(negedge clk);
        end
        // the same request is then taken from idle, one cycle after the last beat
        beat_ready = 1'b0;
        expect_idle();
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(beat_valid && beat_addr == 32'h7770, "R3 deferred request starts", beat_addr, 32'h7770);
        chk(beat_last == 1'b1, "R7 single beat last", AW'(beat_last), 1);
        beat_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        beat_ready = 1'b0;
        expect_idle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_len = '0; req_burst = '0; beat_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        run(32'h00, 2, 3, 1, -1, "R5 aligned incr");
        run(32'h02, 2, 3, 1, 0,  "R5 unaligned incr");
        run(32'h08, 2, 3, 2, 2,  "R6 wrap fold");
        run(32'h40, 2, 3, 0, 1,  "R4 fixed");
        run(32'h1F3, 3, 6, 1, 6, "R5 long incr");
        run(32'h138, 3, 7, 2, 7, "R6 wrap 8 beats");
        run(32'h20, 0, 15, 2, 5, "R6 wrap byte size");
        run(32'h40, 2, 3, 3, -1, "R9 reserved as incr");
        run(32'h08, 2, 2, 2, -1, "R10 bad wrap length");
        run(32'h0A, 2, 3, 2, -1, "R10 unaligned wrap");
        t_busy_ignore();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule